// File: doc/BRIEF.md
# GPIO Bank Controller with Edge Capture

The block serves a bank of general-purpose pins through a word-wide register bus. Software reads the synchronized pin levels. It drives each output latch through separate set and clear words, so no read-modify-write is needed. It chooses the direction, arms rising and falling edge capture independently, and collects captured edges in sticky status bits that raise one interrupt line. Each pin also has a 2-bit function selector. The selector hands the pin's output value and output enable either to the GPIO logic or to one of three peripheral slots, whose signals enter as plain ports.

Pins named by a mask parameter are dedicated pins. They leave reset owned by their peripheral. Selector code 01 turns them into GPIO, and on these pins the direction bit works with inverted sense. Pin inputs pass through a two-flop synchronizer. An edge is a difference between the newest synchronized sample and the sample before it.

Top module: `gpio_bank`

## Requirements
- R1: A register is addressed as {fn[3:0], word}. The low WSEL_W bits pick the 32-bit word and fn picks the function: 0 level, 1 set, 2 clear, 3 direction, 4 rise enable, 5 fall enable, 6 edge status, 7 selector low, 8 selector high. Bit b of word w belongs to pin 32w+b. In selector low/high words, bits [2k+1:2k] belong to pin 32w+k and pin 32w+16+k respectively. Set, clear, unused function codes and pins beyond NUM_PINS read as 0.
- R2: After reset, output latches, direction, both edge enables, edge status and all selectors are 0. Normal pins are GPIO inputs (pad_oe 0). Dedicated pins are driven from peripheral slot 0.
- R3: Writing the set word drives the latch of every pin whose data bit is 1 to 1. Bits written as 0 leave their latches unchanged.
- R4: Writing the clear word drives the latch of every pin whose data bit is 1 to 0. Bits written as 0 leave their latches unchanged.
- R5: The level word returns pad_in through a two-flop synchronizer, whatever the direction. A change driven before a clock edge appears after the second rising edge and not after the first.
- R6: In GPIO use, pad_out equals the pin's latch. A normal pin's pad_oe equals its direction bit (1 = output).
- R7: A synchronized 0-to-1 change sets a pin's status bit when its rise enable is 1. A 1-to-0 change sets it when its fall enable is 1. With both enables set, either change sets it. With neither set, no change sets it.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it. An armed edge in the same cycle as its clear leaves the bit set.
- R9: irq is 1 exactly when some status bit is 1.
- R10: On a normal pin, selector 00 is GPIO and code c in 1..3 drives pad_out/pad_oe from peripheral slot c-1 (per_out/per_oe bit 3*pin+slot).
- R11: On a dedicated pin, selector 00 is slot 0, 01 is GPIO with pad_oe equal to the inverse of the direction bit, 10 is slot 1 and 11 is slot 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address {fn, word} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NUM_PINS | Pin input levels |
| pad_out | output | NUM_PINS | Pin output values |
| pad_oe | output | NUM_PINS | Pin output enables |
| per_out | input | 3*NUM_PINS | Peripheral output values, bit 3*pin+slot |
| per_oe | input | 3*NUM_PINS | Peripheral output enables, bit 3*pin+slot |
| irq | output | 1 | OR of all edge status bits |

## Verification
The bench builds the bank with 40 pins and the top four (36 to 39) dedicated. That gives two register words, one of them partly filled, so the zero padding of absent pins and the split of the selector words can be seen. With only 40 pins, every pin's pad_out and pad_oe can be compared against an arithmetic model for each selector code, for all pins at once and for a per-pin mixed pattern. Edge capture is swept with enable masks that give each pin one of the four enable combinations. The clear-versus-edge race is placed on an exact cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [3:0] {
    FN_LEVEL = 4'd0,
    FN_SET   = 4'd1,
    FN_CLR   = 4'd2,
    FN_DIR   = 4'd3,
    FN_RISE  = 4'd4,
    FN_FALL  = 4'd5,
    FN_STAT  = 4'd6,
    FN_AFLO  = 4'd7,
    FN_AFHI  = 4'd8
  } gpio_fn_e;

  typedef struct packed {
    logic       is_gpio;
    logic [1:0] slot;
  } af_sel_t;

  function automatic int words_for(input int pins);
    return (pins + 31) / 32;
  endfunction

  function automatic int sel_bits(input int words);
    return (words > 1) ? $clog2(words) : 1;
  endfunction

  // selector code to owner; dedicated pins swap codes 00 and 01
  function automatic af_sel_t af_decode(input logic [1:0] code, input logic ded);
    af_sel_t r;
    if (!ded) begin
      r.is_gpio = (code == 2'd0);
      r.slot    = code - 2'd1;
    end else begin
      r.is_gpio = (code == 2'd1);
      r.slot    = (code == 2'd0) ? 2'd0 : code - 2'd1;
    end
    return r;
  endfunction

  function automatic logic gpio_oe(input logic dir_bit, input logic ded);
    return dir_bit ^ ded;
  endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise_ev,
  output logic [N-1:0] fall_ev
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign level   = s2_q;
  assign rise_ev = s2_q & ~s3_q;
  assign fall_ev = ~s2_q & s3_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int N      = 64,
  parameter int WORDS  = words_for(N),
  parameter int WSEL_W = sel_bits(WORDS),
  parameter int ADDR_W = 4 + WSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N-1:0]      level,
  input  logic [N-1:0]      rise_ev,
  input  logic [N-1:0]      fall_ev,
  output logic [N-1:0]      lat,
  output logic [N-1:0]      dir,
  output logic [N-1:0][1:0] af,
  output logic [N-1:0]      status,
  output logic [N-1:0]      edge_hit,
  output logic [N-1:0]      set_hit,
  output logic [N-1:0]      clr_hit,
  output logic [N-1:0]      st_clr
);
  localparam int PADW = WORDS * 32;

  logic [3:0]        fn;
  logic [WSEL_W-1:0] wsel;
  logic [N-1:0]      rise_en_q, fall_en_q, dir_wr, rise_wr, fall_wr, af_wr;
  logic [N-1:0][1:0] af_new;

  assign fn   = bus_addr[ADDR_W-1:WSEL_W];
  assign wsel = bus_addr[WSEL_W-1:0];

  // per-pin write decode
  for (genvar p = 0; p < N; p++) begin : g_dec
    localparam int W = p / 32;
    localparam int B = p % 32;
    localparam int K = p % 16;
    localparam logic [3:0] AF_FN = (B < 16) ? 4'(FN_AFLO) : 4'(FN_AFHI);
    logic hit;
    assign hit        = bus_wr && (int'(wsel) == W);
    assign set_hit[p] = hit && (fn == FN_SET)  && bus_wdata[B];
    assign clr_hit[p] = hit && (fn == FN_CLR)  && bus_wdata[B];
    assign st_clr[p]  = hit && (fn == FN_STAT) && bus_wdata[B];
    assign dir_wr[p]  = hit && (fn == FN_DIR);
    assign rise_wr[p] = hit && (fn == FN_RISE);
    assign fall_wr[p] = hit && (fn == FN_FALL);
    assign af_wr[p]   = hit && (fn == AF_FN);
    assign af_new[p]  = bus_wdata[2*K +: 2];
  end

  assign edge_hit = (rise_ev & rise_en_q) | (fall_ev & fall_en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat       <= '0;
      dir       <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      status    <= '0;
      af        <= '0;
    end else begin
      for (int p = 0; p < N; p++) begin
        if (set_hit[p])      lat[p] <= 1'b1;
        else if (clr_hit[p]) lat[p] <= 1'b0;
        if (dir_wr[p])  dir[p]       <= bus_wdata[p % 32];
        if (rise_wr[p]) rise_en_q[p] <= bus_wdata[p % 32];
        if (fall_wr[p]) fall_en_q[p] <= bus_wdata[p % 32];
        if (af_wr[p])   af[p]        <= af_new[p];
        status[p] <= edge_hit[p] | (status[p] & ~st_clr[p]);
      end
    end
  end

  // read path
  logic [PADW-1:0]             lvl_pad, dir_pad, rise_pad, fall_pad, st_pad;
  logic [WORDS-1:0][31:0]      aflo_w, afhi_w;
  logic [31:0]                 rd_word;

  assign lvl_pad  = PADW'(level);
  assign dir_pad  = PADW'(dir);
  assign rise_pad = PADW'(rise_en_q);
  assign fall_pad = PADW'(fall_en_q);
  assign st_pad   = PADW'(status);

  always_comb begin
    aflo_w = '0;
    afhi_w = '0;
    for (int p = 0; p < N; p++) begin
      if ((p % 32) < 16) aflo_w[p/32][2*(p%16) +: 2] = af[p];
      else               afhi_w[p/32][2*(p%16) +: 2] = af[p];
    end
  end

  always_comb begin
    rd_word = '0;
    if (int'(wsel) < WORDS) begin
      case (fn)
        FN_LEVEL: rd_word = lvl_pad[32*wsel +: 32];
        FN_DIR:   rd_word = dir_pad[32*wsel +: 32];
        FN_RISE:  rd_word = rise_pad[32*wsel +: 32];
        FN_FALL:  rd_word = fall_pad[32*wsel +: 32];
        FN_STAT:  rd_word = st_pad[32*wsel +: 32];
        FN_AFLO:  rd_word = aflo_w[wsel];
        FN_AFHI:  rd_word = afhi_w[wsel];
        default:  rd_word = '0;
      endcase
    end
  end

  assign bus_rdata = rd_word;
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_pkg::*;
#(
  parameter int           N        = 64,
  parameter logic [N-1:0] DED_MASK = '0
) (
  input  logic [N-1:0]      lat,
  input  logic [N-1:0]      dir,
  input  logic [N-1:0][1:0] af,
  input  logic [3*N-1:0]    per_out,
  input  logic [3*N-1:0]    per_oe,
  output logic [N-1:0]      is_gpio,
  output logic [N-1:0]      pad_out,
  output logic [N-1:0]      pad_oe
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    af_sel_t    sel;
    logic [2:0] po, pe;
    assign sel        = af_decode(af[p], DED_MASK[p]);
    assign po         = per_out[3*p +: 3];
    assign pe         = per_oe[3*p +: 3];
    assign is_gpio[p] = sel.is_gpio;
    assign pad_out[p] = sel.is_gpio ? lat[p] : po[sel.slot];
    assign pad_oe[p]  = sel.is_gpio ? gpio_oe(dir[p], DED_MASK[p]) : pe[sel.slot];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int           NUM_PINS = 64,
  parameter logic [NUM_PINS-1:0] DED_MASK = {4'hF, {(NUM_PINS-4){1'b0}}},
  parameter int           WORDS    = words_for(NUM_PINS),
  parameter int           WSEL_W   = sel_bits(WORDS),
  parameter int           ADDR_W   = 4 + WSEL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  input  logic [3*NUM_PINS-1:0] per_out,
  input  logic [3*NUM_PINS-1:0] per_oe,
  output logic                  irq
);
  logic [NUM_PINS-1:0]      level, rise_ev, fall_ev;
  logic [NUM_PINS-1:0]      lat, dir, status, edge_hit, set_hit, clr_hit, st_clr, is_gpio;
  logic [NUM_PINS-1:0][1:0] af;

  gpio_sync_edge #(.N(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .level(level), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  gpio_regs #(.N(NUM_PINS), .WORDS(WORDS), .WSEL_W(WSEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .level(level), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .lat(lat), .dir(dir), .af(af), .status(status), .edge_hit(edge_hit),
    .set_hit(set_hit), .clr_hit(clr_hit), .st_clr(st_clr)
  );

  gpio_pinmux #(.N(NUM_PINS), .DED_MASK(DED_MASK)) u_mux (
    .lat(lat), .dir(dir), .af(af), .per_out(per_out), .per_oe(per_oe),
    .is_gpio(is_gpio), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign irq = |status;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int           N        = 64,
  parameter logic [N-1:0] DED_MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      set_hit,
  input logic [N-1:0]      clr_hit,
  input logic [N-1:0]      lat,
  input logic [N-1:0]      dir,
  input logic [N-1:0][1:0] af,
  input logic [N-1:0]      edge_hit,
  input logic [N-1:0]      status,
  input logic [N-1:0]      st_clr,
  input logic [N-1:0]      pad_oe,
  input logic              irq
);
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit[0] |=> lat[0]);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_hit[0] && !clr_hit[0]) |=> $stable(lat[0]));
  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit[0] |=> !lat[0]);
  p_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!DED_MASK[0] && af[0] == 2'b00) |-> (pad_oe[0] == dir[0]));
  p_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit[0] |=> status[0]);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !st_clr[0]) |=> status[0]);
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr[0] && !edge_hit[0]) |=> !status[0]);
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(edge_hit != '0));
  p_ded_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (DED_MASK[N-1] && af[N-1] == 2'b01) |-> (pad_oe[N-1] == !dir[N-1]));
endmodule

bind gpio_bank gpio_bank_chk #(.N(NUM_PINS), .DED_MASK(DED_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_hit(set_hit), .clr_hit(clr_hit), .lat(lat),
  .dir(dir), .af(af), .edge_hit(edge_hit), .status(status), .st_clr(st_clr),
  .pad_oe(pad_oe), .irq(irq)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int          NP  = 40;
  localparam logic [NP-1:0] DED = 40'hF0_0000_0000;
  localparam int          AW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [3*NP-1:0] per_out, per_oe;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [NP-1:0]      m_lat = '0, m_dir = '0, m_rise = '0, m_fall = '0;
  logic [NP-1:0][1:0] m_af = '0;

  always #10 clk = ~clk;

  gpio_bank #(.NUM_PINS(NP), .DED_MASK(DED)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe),
    .irq(irq)
  );

  function automatic logic [AW-1:0] A(input int f, input int w);
    return {4'(f), 1'(w)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int f, input int w, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A(f, w); bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int f, input int w, output logic [31:0] d);
    @(negedge clk);
    bus_addr = A(f, w);
    #1 d = bus_rdata;
  endtask

  function automatic logic [63:0] w_of(input logic [NP-1:0] v, input int w);
    logic [63:0] x;
    x = 64'(v);
    return {32'd0, x[32*w +: 32]};
  endfunction

  // expected pad_out / pad_oe from R6, R10, R11
  task automatic exp_pads(output logic [NP-1:0] eo, output logic [NP-1:0] ee);
    for (int p = 0; p < NP; p++) begin
      int c;
      int slot;
      c = int'(m_af[p]);
      if (!DED[p]) slot = (c == 0) ? -1 : c - 1;
      else         slot = (c == 1) ? -1 : ((c == 0) ? 0 : c - 1);
      if (slot < 0) begin
        eo[p] = m_lat[p];
        ee[p] = DED[p] ? ~m_dir[p] : m_dir[p];
      end else begin
        eo[p] = per_out[3*p + slot];
        ee[p] = per_oe[3*p + slot];
      end
    end
  endtask

  task automatic check_pads(input string req);
    logic [NP-1:0] eo, ee;
    @(negedge clk);
    exp_pads(eo, ee);
    check({req, " pad_out"}, 64'(pad_out), 64'(eo));
    check({req, " pad_oe"}, 64'(pad_oe), 64'(ee));
  endtask

  task automatic write_af_all();
    for (int w = 0; w < 2; w++) begin
      logic [31:0] lo, hi;
      lo = '0; hi = '0;
      for (int k = 0; k < 16; k++) begin
        if (32*w + k < NP)      lo[2*k +: 2] = m_af[32*w + k];
        if (32*w + 16 + k < NP) hi[2*k +: 2] = m_af[32*w + 16 + k];
      end
      wr(7, w, lo);
      wr(8, w, hi);
    end
  endtask

  initial begin
    for (int i = 0; i < 3*NP; i++) begin
      per_out[i] = ((i % 5) == 1) || ((i % 3) == 0);
      per_oe[i]  = (i % 2) == 1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NP-1:0] pat, rmask, fmask;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2 reset state, R1 read of every function
    for (int f = 0; f < 9; f++)
      for (int w = 0; w < 2; w++) begin
        rd(f, w, d);
        check($sformatf("R2 reset fn%0d w%0d", f, w), 64'(d), 64'd0);
      end
    check_pads("R2 reset");

    // R3 set, no effect of zeros
    wr(1, 0, 32'h0000_FFFF); m_lat[31:0] = 32'h0000_FFFF;
    wr(1, 1, 32'h0000_003C); m_lat[39:32] = 8'h3C;
    check_pads("R3 set");
    wr(1, 0, 32'h0); check_pads("R3 zero no effect");
    // R4 clear
    wr(2, 0, 32'h0000_0F0F); m_lat[31:0] = 32'h0000_F0F0;
    wr(2, 1, 32'h0000_0004); m_lat[39:32] = 8'h38;
    check_pads("R4 clear");
    wr(2, 1, 32'h0); check_pads("R4 zero no effect");

    // R6 direction
    wr(3, 0, 32'hFF00_FF00); m_dir[31:0] = 32'hFF00_FF00;
    wr(3, 1, 32'hFFFF_FF55); m_dir[39:32] = 8'h55;
    check_pads("R6 dir");
    rd(3, 1, d); check("R1 dir word1 padding", 64'(d), 64'h55);
    rd(1, 0, d); check("R1 set reads zero", 64'(d), 64'd0);
    rd(2, 1, d); check("R1 clear reads zero", 64'(d), 64'd0);
    rd(15, 0, d); check("R1 unused fn reads zero", 64'(d), 64'd0);

    // R10 / R11 uniform selector codes
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < NP; p++) m_af[p] = 2'(c);
      write_af_all();
      check_pads($sformatf("R10 R11 code%0d", c));
      rd(7, 1, d);
      check("R1 sel low word1", 64'(d), 64'({8{2'(c)}}));
      rd(8, 1, d);
      check("R1 sel high word1 empty", 64'(d), 64'd0);
    end
    // mixed per-pin codes
    for (int p = 0; p < NP; p++) m_af[p] = 2'((p * 3 + p / 7) % 4);
    write_af_all();
    check_pads("R10 R11 mixed");
    rd(8, 0, d);
    begin
      logic [31:0] e;
      for (int k = 0; k < 16; k++) e[2*k +: 2] = m_af[16 + k];
      check("R1 sel high word0", 64'(d), 64'(e));
    end
    // dedicated pins as GPIO, both direction values
    for (int p = 0; p < NP; p++) m_af[p] = DED[p] ? 2'b01 : 2'b00;
    write_af_all();
    check_pads("R11 ded gpio dir");
    wr(3, 1, 32'h0000_00AA); m_dir[39:32] = 8'hAA;
    check_pads("R11 ded gpio dir flipped");

    // R5 level timing, independent of direction
    pat = 40'hC3_5A0F_F0A5;
    @(negedge clk) pad_in = pat;
    @(posedge clk);
    rd(0, 0, d); check("R5 one edge old", 64'(d), 64'd0);
    @(negedge clk) pad_in = '0;
    @(negedge clk) pad_in = pat;
    @(posedge clk); @(posedge clk);
    rd(0, 0, d); check("R5 level w0", 64'(d), w_of(pat, 0));
    rd(0, 1, d); check("R5 level w1", 64'(d), w_of(pat, 1));
    @(negedge clk) pad_in = '0;
    repeat (4) @(posedge clk);
    wr(6, 0, 32'hFFFF_FFFF); wr(6, 1, 32'hFFFF_FFFF);

    // R7 edges with four enable combinations per pin
    for (int p = 0; p < NP; p++) begin
      rmask[p] = (p % 4 == 1) || (p % 4 == 3);
      fmask[p] = (p % 4 == 2) || (p % 4 == 3);
    end
    m_rise = rmask; m_fall = fmask;
    wr(4, 0, rmask[31:0]); wr(4, 1, 32'(rmask[39:32]));
    wr(5, 0, fmask[31:0]); wr(5, 1, 32'(fmask[39:32]));
    rd(4, 1, d); check("R1 rise en readback", 64'(d), w_of(rmask, 1));
    check("R9 irq idle", 64'(irq), 64'd0);
    @(negedge clk) pad_in = '1;
    repeat (4) @(posedge clk);
    rd(6, 0, d); check("R7 rise w0", 64'(d), w_of(rmask, 0));
    rd(6, 1, d); check("R7 rise w1", 64'(d), w_of(rmask, 1));
    check("R9 irq set", 64'(irq), 64'd1);
    wr(6, 0, 32'hFFFF_FFFF); wr(6, 1, 32'hFFFF_FFFF);
    rd(6, 0, d); check("R8 w1c", 64'(d), 64'd0);
    check("R9 irq cleared", 64'(irq), 64'd0);
    @(negedge clk) pad_in = '0;
    repeat (4) @(posedge clk);
    rd(6, 0, d); check("R7 fall w0", 64'(d), w_of(fmask, 0));
    rd(6, 1, d); check("R7 fall w1", 64'(d), w_of(fmask, 1));
    // R8 zeros ignored, one word cleared alone
    wr(6, 0, 32'h0);
    rd(6, 0, d); check("R8 zero no effect", 64'(d), w_of(fmask, 0));
    wr(6, 1, 32'hFFFF_FFFF);
    rd(6, 0, d); check("R8 other word kept", 64'(d), w_of(fmask, 0));
    rd(6, 1, d); check("R8 word1 cleared", 64'(d), 64'd0);
    wr(6, 0, 32'hFFFF_FFFF);

    // R8 clear colliding with edge on pin 3 (both enables)
    @(negedge clk) pad_in[3] = 1'b1;
    repeat (4) @(posedge clk);
    rd(6, 0, d); check("R7 both enables rise", 64'(d), 64'h8);
    @(negedge clk) pad_in[3] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    wr(6, 0, 32'h8);
    rd(6, 0, d); check("R8 edge beats clear", 64'(d), 64'h8);
    wr(6, 0, 32'h8);
    rd(6, 0, d); check("R8 clear alone", 64'(d), 64'd0);
    check("R9 irq final", 64'(irq), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule